// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter-Receiver

This core moves bytes over a serial data line in one of two modes. In asynchronous mode each character is framed by a low start bit and a high stop bit. The character carries 7 or 8 data bits. After the data there can be a parity bit, or a multiprocessor marker bit that tags the character as an address or as data. In clocked synchronous mode the core drives a shift clock and moves exactly 8 bits in each direction at once. All bit timing comes from an external baud tick, one clock-wide pulse per tick.

Software-side logic writes a byte into a one-deep transmit holding register while `tx_ready` is high. It reads a byte from the receive register when `rx_full` is high and then acknowledges it with `rx_rd`. Parity, framing and overrun faults raise sticky flags, which are cleared together by `err_clr`.

Top module: `dual_mode_serial`

## Requirements
- R1: After reset `tx_ready`=1, `rx_full`=0, all error flags are 0, `sd_out`=1 and `sclk_out`=1.
- R2: `sync_mode`=0 selects asynchronous framing, and `sclk_out` then stays high. `sync_mode`=1 selects clocked synchronous transfer on `sclk_out`.
- R3: An asynchronous frame is sent in this order: start bit 0, the data bits least significant bit first, the optional extra bit, then stop bit 1. Each bit lasts OVERSAMPLE (16) baud ticks. The receiver samples each bit at tick OVERSAMPLE/2 after the start edge.
- R4: With `char7`=1 in asynchronous mode only bits 6..0 are sent, and bit 7 of the written byte is dropped. The received `rx_data[7]` reads 0.
- R5: With `parity_en`=1 and `mp_en`=0, a parity bit follows the data. The data plus parity hold an even number of ones when `parity_odd`=0 and an odd number when `parity_odd`=1. On receive, a mismatch sets `parity_err`.
- R6: With `mp_en`=1, exactly one bit equal to `tx_mpb` follows the data, and no parity bit is sent or checked whatever `parity_en` holds. The received marker appears on `rx_mpb`.
- R7: A stop bit sampled as 0 sets `frame_err`, and the byte is still delivered.
- R8: In synchronous mode exactly 8 bits are moved whatever `char7` and `parity_en` hold. `sd_out` changes on falling edges of `sclk_out`, and `sd_in` is sampled on its rising edges. The byte taken in appears in `rx_data`.
- R9: Writing with `tx_wr` while `tx_ready`=1 drops `tx_ready` on the next cycle. It rises again once the byte has moved into the shifter, which happens one cycle later when the shifter is idle, or when the frame in progress ends.
- R10: A completed reception sets `rx_full`, and `rx_rd` clears it.
- R11: A reception that completes while `rx_full`=1 (and no `rx_rd` in that cycle) sets `overrun_err` and leaves `rx_data` unchanged.
- R12: The error flags are sticky until `err_clr`, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sync_mode | input | 1 | 0 asynchronous, 1 clocked synchronous |
| char7 | input | 1 | 7-bit character in asynchronous mode |
| parity_en | input | 1 | Append and check parity (asynchronous) |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| mp_en | input | 1 | Multiprocessor marker bit instead of parity |
| baud_tick | input | 1 | One pulse per baud tick |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| tx_mpb | input | 1 | Marker bit sent with the byte in multiprocessor format |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_rd | input | 1 | Acknowledges the received byte |
| rx_data | output | 8 | Received byte |
| rx_mpb | output | 1 | Received marker bit |
| rx_full | output | 1 | Received byte waiting |
| parity_err | output | 1 | Sticky parity fault |
| frame_err | output | 1 | Sticky framing fault |
| overrun_err | output | 1 | Sticky overrun fault |
| err_clr | input | 1 | Clears all error flags |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| sclk_out | output | 1 | Shift clock out, idle high |

## Verification
The bench keeps the default OVERSAMPLE of 16 and pulses the baud tick every second clock. A full 11-bit asynchronous frame therefore takes about 350 clocks, so dozens of random configurations fit in the run. Sending bit by bit through a loopback with the bench's own line driver puts wrong parity, a low stop bit, back-to-back frames and the marker-over-parity override within reach.

// File: rtl/dual_mode_serial.sv
module dual_mode_serial #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic       char7,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       mp_en,
  input  logic       baud_tick,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tx_mpb,
  output logic       tx_ready,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_mpb,
  output logic       rx_full,
  output logic       parity_err,
  output logic       frame_err,
  output logic       overrun_err,
  input  logic       err_clr,
  input  logic       sd_in,
  output logic       sd_out,
  output logic       sclk_out
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2);

  wire       extra    = mp_en | parity_en;
  wire [3:0] nd       = char7 ? 4'd7 : 4'd8;
  wire [7:0] dmask    = char7 ? 8'h7F : 8'hFF;
  wire [3:0] stop_idx = extra ? nd + 4'd2 : nd + 4'd1;

  logic [7:0]    tdr;
  logic          tdr_full, tdr_mpb;
  logic          tx_busy, sync_ph, sclk_q, txd_q;
  logic [10:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [CW-1:0] tx_cnt;
  logic [7:0]    srx_sh;

  logic [10:0] afr;
  logic [3:0]  alen;
  always_comb begin
    afr = '1;
    afr[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < nd) afr[i+1] = tdr[i];
    alen = nd + 4'd2;
    if (mp_en) begin
      afr[nd + 4'd1] = tdr_mpb;
      alen = nd + 4'd3;
    end else if (parity_en) begin
      afr[nd + 4'd1] = ^(tdr & dmask) ^ parity_odd;
      alen = nd + 4'd3;
    end
  end

  assign tx_ready = !tdr_full;
  assign sclk_out = sclk_q;
  assign sd_out   = sync_mode ? txd_q : (tx_busy ? tx_sh[0] : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr <= '0; tdr_mpb <= 1'b0; tdr_full <= 1'b0;
      tx_busy <= 1'b0; tx_sh <= '1; tx_left <= '0; tx_cnt <= '0;
      sync_ph <= 1'b0; sclk_q <= 1'b1; txd_q <= 1'b1; srx_sh <= '0;
    end else begin
      if (tx_wr && !tdr_full) begin
        tdr <= tx_data; tdr_mpb <= tx_mpb; tdr_full <= 1'b1;
      end
      if (!tx_busy) begin
        if (tdr_full) begin
          tdr_full <= 1'b0; tx_busy <= 1'b1; tx_cnt <= '0; sync_ph <= 1'b0;
          if (sync_mode) begin
            tx_sh <= {3'b111, tdr}; tx_left <= 4'd8;
          end else begin
            tx_sh <= afr; tx_left <= alen;
          end
        end
      end else if (baud_tick) begin
        if (sync_mode) begin
          if (!sync_ph) begin
            sclk_q <= 1'b0; txd_q <= tx_sh[0];
            tx_sh <= {1'b1, tx_sh[10:1]}; sync_ph <= 1'b1;
          end else begin
            sclk_q <= 1'b1; srx_sh <= {sd_in, srx_sh[7:1]}; sync_ph <= 1'b0;
            tx_left <= tx_left - 4'd1;
            if (tx_left == 4'd1) tx_busy <= 1'b0;
          end
        end else begin
          tx_cnt <= (tx_cnt == LAST) ? '0 : tx_cnt + 1'b1;
          if (tx_cnt == LAST) begin
            tx_sh <= {1'b1, tx_sh[10:1]}; tx_left <= tx_left - 4'd1;
            if (tx_left == 4'd1) tx_busy <= 1'b0;
          end
        end
      end
    end
  end

  wire sync_done = tx_busy && sync_mode && baud_tick && sync_ph && (tx_left == 4'd1);

  logic          rx_busy, rx_xbit;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_idx;
  logic [7:0]    arx_sh;

  wire rx_samp    = rx_busy && baud_tick && (rx_cnt == MID);
  wire async_done = rx_samp && (rx_idx == stop_idx);
  wire deliver    = async_done | sync_done;
  wire par_bad    = parity_en && !mp_en && ((^arx_sh ^ rx_xbit) != parity_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_cnt <= '0; rx_idx <= '0; arx_sh <= '0; rx_xbit <= 1'b0;
    end else if (sync_mode) begin
      rx_busy <= 1'b0;
    end else if (!rx_busy) begin
      if (baud_tick && !sd_in) begin
        rx_busy <= 1'b1; rx_cnt <= CW'(1); rx_idx <= '0; arx_sh <= '0;
      end
    end else if (baud_tick) begin
      rx_cnt <= (rx_cnt == LAST) ? '0 : rx_cnt + 1'b1;
      if (rx_cnt == MID) begin
        rx_idx <= rx_idx + 4'd1;
        if (rx_idx == 4'd0) begin
          if (sd_in) rx_busy <= 1'b0;
        end else if (rx_idx <= nd) begin
          arx_sh[3'(rx_idx - 4'd1)] <= sd_in;
        end else if (rx_idx == stop_idx) begin
          rx_busy <= 1'b0;
        end else begin
          rx_xbit <= sd_in;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_mpb <= 1'b0; rx_full <= 1'b0;
      parity_err <= 1'b0; frame_err <= 1'b0; overrun_err <= 1'b0;
    end else begin
      if (err_clr) begin
        parity_err <= 1'b0; frame_err <= 1'b0; overrun_err <= 1'b0;
      end
      if (deliver) begin
        if (rx_full && !rx_rd) begin
          overrun_err <= 1'b1;
        end else begin
          rx_data <= sync_done ? {sd_in, srx_sh[7:1]} : arx_sh;
          rx_mpb  <= async_done && mp_en && rx_xbit;
          rx_full <= 1'b1;
        end
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end
      if (async_done) begin
        if (!sd_in) frame_err <= 1'b1;
        if (par_bad) parity_err <= 1'b1;
      end
    end
  end

  // R9
  tx_ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_ready |=> !tx_ready);
  // R11
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver && rx_full && !rx_rd |=> overrun_err && $stable(rx_data));
  // R10
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !deliver |=> !rx_full);
  // R2
  sclk_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> $stable(sclk_out));
  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode && !tx_busy && !tx_ready |=> !sd_out);
  // R12
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !deliver |=> !parity_err && !frame_err && !overrun_err);
endmodule

// File: tb/dual_mode_serial_tb.sv
module dual_mode_serial_tb;
  localparam int P = 2;
  localparam int BITC = 16 * P;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_mode = 0, char7 = 0, parity_en = 0, parity_odd = 0, mp_en = 0;
  logic baud_tick = 0, tx_wr = 0, tx_mpb = 0, rx_rd = 0, err_clr = 0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_mpb, rx_full, parity_err, frame_err, overrun_err, sd_out, sclk_out;
  logic [7:0] rx_data;
  logic inject = 0, line = 1;
  wire  sd_in = inject ? line : sd_out;
  int nchk = 0, nfail = 0, cyc = 0, tcnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_mode_serial u_dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .char7(char7),
    .parity_en(parity_en), .parity_odd(parity_odd), .mp_en(mp_en),
    .baud_tick(baud_tick), .tx_wr(tx_wr), .tx_data(tx_data), .tx_mpb(tx_mpb),
    .tx_ready(tx_ready), .rx_rd(rx_rd), .rx_data(rx_data), .rx_mpb(rx_mpb),
    .rx_full(rx_full), .parity_err(parity_err), .frame_err(frame_err),
    .overrun_err(overrun_err), .err_clr(err_clr), .sd_in(sd_in),
    .sd_out(sd_out), .sclk_out(sclk_out));

  always @(negedge clk) begin
    tcnt <= (tcnt == P - 1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == P - 1);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic m);
    tx_data = d; tx_mpb = m; tx_wr = 1;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic ack();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic c7, pe, po, mp, mpb,
                                            output int len);
    int n = c7 ? 7 : 8;
    logic [10:0] f = '1;
    logic p = po;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin f[i+1] = d[i]; p ^= d[i]; end
    len = n + 2;
    if (mp) begin f[n+1] = mpb; len = n + 3; end
    else if (pe) begin f[n+1] = p; len = n + 3; end
    return f;
  endfunction

  task automatic cap_async(input int len, output logic [10:0] got, output bit ok);
    int t = 0;
    got = '1; ok = 1;
    while (sd_out !== 1'b0 && t < 300) begin @(negedge clk); t++; end
    if (t >= 300) ok = 0;
    clks(8 * P);
    for (int k = 0; k < len; k++) begin
      got[k] = sd_out;
      if (k < len - 1) clks(BITC);
    end
  endtask

  task automatic async_case(input logic [7:0] d, input logic c7, pe, po, mp, mpb);
    int len; logic [10:0] ef, got; bit ok;
    sync_mode = 0; char7 = c7; parity_en = pe; parity_odd = po; mp_en = mp;
    clks(2);
    ef = exp_frame(d, c7, pe, po, mp, mpb, len);
    wr(d, mpb);
    cap_async(len, got, ok);
    // R3 R4 R5 R6: line frame bit by bit
    chk(ok && got == ef, "R3/R4/R5/R6 frame", int'(got), int'(ef));
    chk(sclk_out == 1'b1, "R2 sclk idle async", sclk_out, 1);
    clks(3 * P + 2);
    chk(rx_full == 1'b1, "R10 rx_full", rx_full, 1);
    chk(rx_data == (c7 ? d & 8'h7F : d), "R4 rx_data", rx_data, c7 ? d & 8'h7F : d);
    if (mp) chk(rx_mpb == mpb, "R6 rx_mpb", rx_mpb, mpb);
    chk(!parity_err && !frame_err && !overrun_err, "R5 no error",
        {parity_err, frame_err, overrun_err}, 0);
    ack();
    chk(rx_full == 1'b0, "R10 rx_rd clears", rx_full, 0);
    clks(BITC);
  endtask

  task automatic sync_case(input logic [7:0] d, input logic c7, pe);
    int rises = 0, falls = 0, t = 0;
    logic prev; logic [7:0] got = '0;
    sync_mode = 1; char7 = c7; parity_en = pe; mp_en = 0;
    clks(2);
    wr(d, 1'b0);
    prev = sclk_out;
    while (rises < 8 && t < 1000) begin
      @(negedge clk); t++;
      if (prev && !sclk_out) falls++;
      if (!prev && sclk_out) begin got[rises] = sd_out; rises++; end
      prev = sclk_out;
    end
    chk(got == d && falls == 8, "R8 sync bits", int'(got), int'(d));
    clks(6 * P);
    chk(sclk_out == 1'b1, "R8 eight clocks only", sclk_out, 1);
    chk(rx_full && rx_data == d, "R8 sync receive", rx_data, d);
    ack();
    sync_mode = 0;
    clks(4);
  endtask

  task automatic drive_frame(input logic [10:0] bits, input int len);
    inject = 1;
    for (int k = 0; k < len; k++) begin line = bits[k]; clks(BITC); end
    line = 1;
    clks(BITC * 2);
    inject = 0;
  endtask

  initial begin
    int len; logic [10:0] f;
    void'($urandom(32'd2024));
    clks(3);
    rst_n = 1;
    clks(1);
    // R1
    chk(tx_ready && !rx_full && sd_out && sclk_out, "R1 reset outputs",
        {tx_ready, rx_full, sd_out, sclk_out}, 4'b1011);
    chk(!parity_err && !frame_err && !overrun_err, "R1 reset errors",
        {parity_err, frame_err, overrun_err}, 0);

    async_case(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    async_case(8'h81, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 24; i++)
      async_case(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
    sync_case(8'hA6, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++)
      sync_case(8'($urandom), 1'($urandom), 1'($urandom));

    // R5 parity error: A5 has even ones, even parity bit is 0, send 1
    sync_mode = 0; char7 = 0; parity_en = 1; parity_odd = 0; mp_en = 0;
    f = exp_frame(8'hA5, 0, 1, 0, 0, 0, len);
    f[9] = 1'b1;
    drive_frame(f, len);
    chk(parity_err == 1'b1 && frame_err == 1'b0, "R5 parity_err", parity_err, 1);
    chk(rx_full && rx_data == 8'hA5, "R5 data kept", rx_data, 8'hA5);
    ack();
    // R12
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(!parity_err && !frame_err && !overrun_err, "R12 clear",
        {parity_err, frame_err, overrun_err}, 0);

    // R7 low stop bit
    parity_en = 0;
    f = exp_frame(8'h3C, 0, 0, 0, 0, 0, len);
    f[9] = 1'b0;
    drive_frame(f, len);
    chk(frame_err == 1'b1, "R7 frame_err", frame_err, 1);
    chk(rx_full && rx_data == 8'h3C, "R7 data delivered", rx_data, 8'h3C);
    clks(BITC);
    chk(frame_err == 1'b1, "R12 sticky", frame_err, 1);
    ack();
    err_clr = 1; @(negedge clk); err_clr = 0;

    // R6 marker overrides parity on receive: parity bit wrong but mp_en
    mp_en = 1; parity_en = 1;
    f = exp_frame(8'h5A, 0, 0, 0, 1, 1, len);
    drive_frame(f, len);
    chk(!parity_err && rx_mpb && rx_data == 8'h5A, "R6 no parity check", parity_err, 0);
    ack();
    mp_en = 0; parity_en = 0;
    clks(4);

    // R9 handshake and R11 overrun via back-to-back loopback frames
    wr(8'h11, 1'b0);
    chk(tx_ready == 1'b0, "R9 ready drops", tx_ready, 0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R9 ready returns", tx_ready, 1);
    wr(8'h22, 1'b0);
    clks(20);
    chk(tx_ready == 1'b0, "R9 held while busy", tx_ready, 0);
    begin
      int t = 0;
      while (!tx_ready && t < 1000) begin @(negedge clk); t++; end
    end
    clks(BITC * 12);
    chk(overrun_err == 1'b1, "R11 overrun flag", overrun_err, 1);
    chk(rx_full && rx_data == 8'h11, "R11 data kept", rx_data, 8'h11);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(!overrun_err, "R12 overrun cleared", overrun_err, 0);
    ack();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule